// File: doc/BRIEF.md
# NAND flash command sequencer

This block is the command-level controller inside a NAND flash device model. A host writes single bytes on a shared data bus, marking each as a command or an address. The sequencer decodes the command opcode and gathers the column and row address bytes that belong to it. It then waits for the matching confirm opcode and models the array busy time with a down-counter. A status byte is readable at all times and carries a ready flag, a fail flag and a write-allowed flag.

Identification and parameter-page requests are answered through a response selector. This selector names the current data source, its length, and for the short sources the data word itself. Page reads, page programs and block erases are handed to a storage-side port as one-cycle operation pulses. That port receives the decoded logical unit, block, page and column, and it answers with a block-valid flag. The storage array itself is not part of this block.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset the block accepts only the RESET opcode 0xFF. Any other command or any address byte raises `err_evt` for one cycle and leaves the block waiting for RESET. RESET moves it to idle with ready set and `rsp_src` cleared to 0, and RESET is also accepted in every state except busy.
- R2: In idle the opcodes are 0x90 (identify), 0xEC (parameter page), 0x00 (page read, confirm 0x30), 0x80 (page program, confirm 0x10) and 0x60 (block erase, confirm 0xD0). Any other command byte in idle raises `err_evt`.
- R3: `cfg_addr_cyc[3:0]` sets the number of row bytes and `cfg_addr_cyc[7:4]` sets the number of column bytes. A count of 0 acts as 1, and a count above the parameter maximum acts as the maximum. Bytes are stored least significant first.
- R4: Read and program take column bytes, then row bytes, then the confirm; erase takes row bytes only. The row splits into page = row[PG_W-1:0], block = the next BLK_W bits and unit = the remaining upper bits, all shown on the storage port.
- R5: Any command accepted in idle clears the fail flag, status bit 0.
- R6: For program or erase, if `st_blk_ok` is low for the addressed block, status bit 0 is set one cycle after the last row byte. The confirm is still accepted.
- R7: A confirm with a nonzero delay for its operation clears ready (status bit 6) for exactly that many clock cycles and then returns to idle. With a zero delay, ready stays set and the block is idle on the next cycle.
- R8: While busy, command and address strobes raise `err_evt`, are otherwise ignored and do not shorten or extend the busy time.
- R9: The cycle after a confirm, `st_op_vld` pulses with `st_op` 1 for read, 2 for program, or 3 for an erase fill to all-ones. The fill pulse is given only if the block is valid. Every erase confirm also pulses `st_wear_dec` one cycle later. Read and program set `rsp_src` to 4 (page).
- R10: After 0x90, address 0x00 selects `rsp_src` 1 with length 2 and word {dev, man} (manufacturer in bits 7:0). Address 0x20 selects `rsp_src` 2 with length 4 and word 0x49464E4F, the letters O N F I from byte 0 up. Any other address pulses `err_addr` and clears `rsp_src` to 0. In every case the block then returns to idle.
- R11: After 0xEC, address 0x00 selects `rsp_src` 3 with length PARAM_BYTES. Any other address pulses `err_addr`.
- R12: Address bytes that arrive while a confirm is awaited are ignored, with no error and no change of address. A wrong command during address collection or confirm wait raises `err_evt` and returns to idle.
- R13: Status bit 7 is the inverse of `wp_in` as sampled during reset and holds that value until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command strobe for `bus_din` |
| addr_we | input | 1 | Address strobe for `bus_din` |
| bus_din | input | 8 | Host byte |
| cfg_addr_cyc | input | 8 | Column count (high nibble), row count (low nibble) |
| cfg_rd_dly | input | DLY_W | Read busy cycles |
| cfg_pg_dly | input | DLY_W | Program busy cycles |
| cfg_er_dly | input | DLY_W | Erase busy cycles |
| wp_in | input | 1 | Write-protect level sampled at reset |
| man_id | input | 8 | Manufacturer code |
| dev_id | input | 8 | Device code |
| status_q | output | 8 | Status byte: bit 7 write-allowed, bit 6 ready, bit 0 fail |
| err_evt | output | 1 | Unexpected strobe pulse |
| err_addr | output | 1 | Unsupported identify/parameter address pulse |
| rsp_src | output | 3 | Data source: 0 none, 1 id, 2 signature, 3 parameter, 4 page |
| rsp_word | output | 32 | Data word for id and signature sources |
| rsp_len | output | 16 | Byte length of the selected source |
| st_lun | output | RW-PG_W-BLK_W | Decoded logical unit |
| st_blk | output | BLK_W | Decoded block |
| st_page | output | PG_W | Decoded page |
| st_col | output | 8*MAX_COL_CYC | Decoded column |
| st_blk_ok | input | 1 | Storage answer: block usable |
| st_op_vld | output | 1 | Storage operation pulse |
| st_op | output | 2 | Operation: 1 read, 2 program, 3 erase fill |
| st_wear_dec | output | 1 | Wear-decrement pulse for `st_blk` |

## Verification
The bench first probes the power-up state with foreign opcodes and address bytes. A design that left that state too early would show an identify response rather than an error. It counts the exact number of cycles that ready stays low. This exposes off-by-one loading of the busy counter, and it also checks that a strobe during busy neither ends the wait nor restarts it. It runs a program and an erase on a block the storage side rejects. A wrong design would drop the fail flag, skip the confirm, still emit an erase fill, or forget the wear pulse; the operation scoreboard catches any extra or missing pulse. It also changes the address-count nibbles, including zero, to catch a collector that ignores the configuration or hangs waiting for a byte that never comes.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam logic [7:0] OPC_RESET    = 8'hFF;
    localparam logic [7:0] OPC_IDENT    = 8'h90;
    localparam logic [7:0] OPC_PARAM    = 8'hEC;
    localparam logic [7:0] OPC_READ     = 8'h00;
    localparam logic [7:0] OPC_READ_GO  = 8'h30;
    localparam logic [7:0] OPC_PROG     = 8'h80;
    localparam logic [7:0] OPC_PROG_GO  = 8'h10;
    localparam logic [7:0] OPC_ERASE    = 8'h60;
    localparam logic [7:0] OPC_ERASE_GO = 8'hD0;

    localparam logic [7:0]  SIG_ADDR = 8'h20;
    localparam logic [31:0] SIG_WORD = 32'h4946_4E4F;

    typedef enum logic [2:0] {
        ST_PWRUP, ST_IDLE, ST_COL, ST_ROW, ST_ONE, ST_CONF, ST_BUSY
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_READ, OP_PROG, OP_ERASE, OP_IDENT, OP_PARAM
    } seq_op_e;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0, SRC_ID = 3'd1, SRC_SIG = 3'd2, SRC_PARAM = 3'd3, SRC_PAGE = 3'd4
    } src_e;

    typedef enum logic [1:0] {
        STO_NONE = 2'd0, STO_READ = 2'd1, STO_PROG = 2'd2, STO_FILL = 2'd3
    } sto_e;

    typedef struct packed {
        logic wr_ok;
        logic ready;
        logic fail;
    } stat_t;

    function automatic logic [3:0] eff_cycles(input logic [3:0] nib, input logic [3:0] maxc);
        if (nib == 4'd0)
            return 4'd1;
        else if (nib > maxc)
            return maxc;
        else
            return nib;
    endfunction

    function automatic logic [7:0] confirm_of(input seq_op_e op);
        case (op)
            OP_READ:  return OPC_READ_GO;
            OP_PROG:  return OPC_PROG_GO;
            OP_ERASE: return OPC_ERASE_GO;
            default:  return OPC_RESET;
        endcase
    endfunction

    function automatic logic is_idle_opcode(input logic [7:0] b);
        return (b == OPC_RESET) || (b == OPC_IDENT) || (b == OPC_PARAM) ||
               (b == OPC_READ) || (b == OPC_PROG) || (b == OPC_ERASE);
    endfunction

endpackage

// File: rtl/nand_addr_collect.sv
module nand_addr_collect
    import nand_seq_pkg::*;
#(
    parameter int MAX_COL_CYC = 2,
    parameter int MAX_ROW_CYC = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     col_en,
    input  logic                     row_en,
    input  logic [7:0]               din,
    input  logic [3:0]               col_need,
    input  logic [3:0]               row_need,
    output logic [8*MAX_COL_CYC-1:0] col_q,
    output logic [8*MAX_ROW_CYC-1:0] row_q,
    output logic                     col_done,
    output logic                     row_done
);
    localparam int CW   = 8 * MAX_COL_CYC;
    localparam int RW   = 8 * MAX_ROW_CYC;
    localparam int MAXC = (MAX_COL_CYC > MAX_ROW_CYC) ? MAX_COL_CYC : MAX_ROW_CYC;

    logic [3:0] cnt;
    logic [3:0] need;
    logic       last;

    assign need     = col_en ? col_need : row_need;
    assign last     = (col_en || row_en) && (4'(cnt + 4'd1) == need);
    assign col_done = col_en && last;
    assign row_done = row_en && last;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt   <= '0;
            col_q <= '0;
            row_q <= '0;
        end else if (col_en || row_en) begin
            for (int i = 0; i < MAX_COL_CYC; i++)
                if (col_en && cnt == 4'(i))
                    col_q[i*8 +: 8] <= din;
            for (int i = 0; i < MAX_ROW_CYC; i++)
                if (row_en && cnt == 4'(i))
                    row_q[i*8 +: 8] <= din;
            cnt <= last ? 4'd0 : 4'(cnt + 4'd1);
        end
    end

    // R3: the byte index never runs past the widest field
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt < 4'(MAXC));

    // R3: a completed field restarts the byte counter
    p_cnt_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (col_done || row_done) |=> (cnt == 4'd0));

    logic unused_w;
    assign unused_w = ^{CW, RW};
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    output logic             busy,
    output logic             expire
);
    logic [DLY_W-1:0] cnt;

    assign busy   = (cnt != '0);
    assign expire = (cnt == DLY_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (busy)
            cnt <= cnt - DLY_W'(1);
    end

    // R7: a new delay is only loaded once the previous one has run out
    p_load_idle_r7: assert property (@(posedge clk) disable iff (rst)
        load |-> !busy);
endmodule

// File: rtl/nand_resp_sel.sv
module nand_resp_sel
    import nand_seq_pkg::*;
#(
    parameter int PARAM_BYTES = 256,
    parameter int PAGE_BYTES  = 2112
) (
    input  src_e        src,
    input  logic [7:0]  man,
    input  logic [7:0]  dev,
    output logic [31:0] word,
    output logic [15:0] len
);
    always_comb begin
        word = '0;
        len  = '0;
        case (src)
            SRC_ID: begin
                word = {16'h0, dev, man};
                len  = 16'd2;
            end
            SRC_SIG: begin
                word = SIG_WORD;
                len  = 16'd4;
            end
            SRC_PARAM: len = 16'(PARAM_BYTES);
            SRC_PAGE:  len = 16'(PAGE_BYTES);
            default: ;
        endcase
    end
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int DLY_W       = 16,
    parameter int MAX_COL_CYC = 2,
    parameter int MAX_ROW_CYC = 3,
    parameter int PG_W        = 6,
    parameter int BLK_W       = 10,
    parameter int PARAM_BYTES = 256,
    parameter int PAGE_BYTES  = 2112,
    localparam int CW         = 8 * MAX_COL_CYC,
    localparam int RW         = 8 * MAX_ROW_CYC,
    localparam int LUN_W      = RW - PG_W - BLK_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_we,
    input  logic             addr_we,
    input  logic [7:0]       bus_din,
    input  logic [7:0]       cfg_addr_cyc,
    input  logic [DLY_W-1:0] cfg_rd_dly,
    input  logic [DLY_W-1:0] cfg_pg_dly,
    input  logic [DLY_W-1:0] cfg_er_dly,
    input  logic             wp_in,
    input  logic [7:0]       man_id,
    input  logic [7:0]       dev_id,
    output logic [7:0]       status_q,
    output logic             err_evt,
    output logic             err_addr,
    output logic [2:0]       rsp_src,
    output logic [31:0]      rsp_word,
    output logic [15:0]      rsp_len,
    output logic [LUN_W-1:0] st_lun,
    output logic [BLK_W-1:0] st_blk,
    output logic [PG_W-1:0]  st_page,
    output logic [CW-1:0]    st_col,
    input  logic             st_blk_ok,
    output logic             st_op_vld,
    output logic [1:0]       st_op,
    output logic             st_wear_dec
);
    seq_state_e       state;
    seq_op_e          op;
    src_e             src;
    stat_t            stat;
    sto_e             sto;
    logic             chk_pend;
    logic             wear_pend;

    logic             col_en, row_en, clr_addr, col_done, row_done;
    logic [3:0]       col_need, row_need;
    logic [RW-1:0]    row_q;
    logic [CW-1:0]    col_q;
    logic             tmr_load, tmr_busy, tmr_expire;
    logic [DLY_W-1:0] sel_dly;
    logic             conf_go, strobe_cmd, strobe_addr;

    assign strobe_cmd  = cmd_we;
    assign strobe_addr = addr_we && !cmd_we;

    assign col_need = eff_cycles(cfg_addr_cyc[7:4], 4'(MAX_COL_CYC));
    assign row_need = eff_cycles(cfg_addr_cyc[3:0], 4'(MAX_ROW_CYC));
    assign col_en   = strobe_addr && (state == ST_COL);
    assign row_en   = strobe_addr && (state == ST_ROW);
    assign clr_addr = strobe_cmd && (state == ST_IDLE);

    always_comb begin
        case (op)
            OP_READ:  sel_dly = cfg_rd_dly;
            OP_PROG:  sel_dly = cfg_pg_dly;
            OP_ERASE: sel_dly = cfg_er_dly;
            default:  sel_dly = '0;
        endcase
    end

    assign conf_go  = (state == ST_CONF) && strobe_cmd && (bus_din == confirm_of(op));
    assign tmr_load = conf_go && (sel_dly != '0);

    nand_addr_collect #(
        .MAX_COL_CYC(MAX_COL_CYC),
        .MAX_ROW_CYC(MAX_ROW_CYC)
    ) u_addr (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr_addr),
        .col_en   (col_en),
        .row_en   (row_en),
        .din      (bus_din),
        .col_need (col_need),
        .row_need (row_need),
        .col_q    (col_q),
        .row_q    (row_q),
        .col_done (col_done),
        .row_done (row_done)
    );

    nand_busy_timer #(.DLY_W(DLY_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (sel_dly),
        .busy     (tmr_busy),
        .expire   (tmr_expire)
    );

    nand_resp_sel #(
        .PARAM_BYTES(PARAM_BYTES),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_resp (
        .src  (src),
        .man  (man_id),
        .dev  (dev_id),
        .word (rsp_word),
        .len  (rsp_len)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_PWRUP;
            op          <= OP_NONE;
            src         <= SRC_NONE;
            stat.wr_ok  <= !wp_in;
            stat.ready  <= 1'b1;
            stat.fail   <= 1'b0;
            err_evt     <= 1'b0;
            err_addr    <= 1'b0;
            st_op_vld   <= 1'b0;
            sto         <= STO_NONE;
            wear_pend   <= 1'b0;
            st_wear_dec <= 1'b0;
            chk_pend    <= 1'b0;
        end else begin
            err_evt     <= 1'b0;
            err_addr    <= 1'b0;
            st_op_vld   <= 1'b0;
            sto         <= STO_NONE;
            st_wear_dec <= wear_pend;
            wear_pend   <= 1'b0;
            chk_pend    <= 1'b0;

            if (tmr_expire) begin
                stat.ready <= 1'b1;
                state      <= ST_IDLE;
            end

            case (state)
                ST_PWRUP: begin
                    if (strobe_cmd && bus_din == OPC_RESET) begin
                        state      <= ST_IDLE;
                        src        <= SRC_NONE;
                        stat.ready <= 1'b1;
                    end else if (strobe_cmd || addr_we) begin
                        err_evt <= 1'b1;
                    end
                end

                ST_IDLE: begin
                    if (strobe_cmd) begin
                        if (is_idle_opcode(bus_din))
                            stat.fail <= 1'b0;
                        case (bus_din)
                            OPC_RESET: begin
                                src        <= SRC_NONE;
                                stat.ready <= 1'b1;
                            end
                            OPC_IDENT: begin
                                op <= OP_IDENT; state <= ST_ONE;
                            end
                            OPC_PARAM: begin
                                op <= OP_PARAM; state <= ST_ONE;
                            end
                            OPC_READ: begin
                                op <= OP_READ; state <= ST_COL;
                            end
                            OPC_PROG: begin
                                op <= OP_PROG; state <= ST_COL;
                            end
                            OPC_ERASE: begin
                                op <= OP_ERASE; state <= ST_ROW;
                            end
                            default: err_evt <= 1'b1;
                        endcase
                    end else if (addr_we) begin
                        err_evt <= 1'b1;
                    end
                end

                ST_COL, ST_ROW, ST_ONE, ST_CONF: begin
                    if (conf_go) begin
                        case (op)
                            OP_READ: begin
                                st_op_vld <= 1'b1; sto <= STO_READ; src <= SRC_PAGE;
                            end
                            OP_PROG: begin
                                st_op_vld <= 1'b1; sto <= STO_PROG; src <= SRC_PAGE;
                            end
                            default: begin
                                if (st_blk_ok) begin
                                    st_op_vld <= 1'b1; sto <= STO_FILL;
                                end
                                wear_pend <= 1'b1;
                                src       <= SRC_NONE;
                            end
                        endcase
                        if (sel_dly != '0) begin
                            stat.ready <= 1'b0;
                            state      <= ST_BUSY;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else if (strobe_cmd && bus_din == OPC_RESET) begin
                        state      <= ST_IDLE;
                        src        <= SRC_NONE;
                        stat.ready <= 1'b1;
                    end else if (strobe_cmd) begin
                        err_evt <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (col_done) begin
                        state <= ST_ROW;
                    end else if (row_done) begin
                        state <= ST_CONF;
                        if (op == OP_PROG || op == OP_ERASE)
                            chk_pend <= 1'b1;
                    end else if (strobe_addr && state == ST_ONE) begin
                        state <= ST_IDLE;
                        if (op == OP_IDENT && bus_din == 8'h00)
                            src <= SRC_ID;
                        else if (op == OP_IDENT && bus_din == SIG_ADDR)
                            src <= SRC_SIG;
                        else if (op == OP_PARAM && bus_din == 8'h00)
                            src <= SRC_PARAM;
                        else begin
                            src      <= SRC_NONE;
                            err_addr <= 1'b1;
                        end
                    end
                end

                ST_BUSY: begin
                    if (strobe_cmd || addr_we)
                        err_evt <= 1'b1;
                end

                default: state <= ST_IDLE;
            endcase

            if (chk_pend && !st_blk_ok)
                stat.fail <= 1'b1;
        end
    end

    assign status_q = {stat.wr_ok, stat.ready, 5'b0, stat.fail};
    assign rsp_src  = src;
    assign st_op    = sto;
    assign st_col   = col_q;
    assign st_page  = row_q[PG_W-1:0];
    assign st_blk   = row_q[PG_W +: BLK_W];
    assign st_lun   = row_q[RW-1 -: LUN_W];

    // R1: a foreign command before RESET keeps the power-up state and is flagged
    p_pwrup_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PWRUP && cmd_we && bus_din != OPC_RESET) |=> (state == ST_PWRUP && err_evt));

    // R5: a command accepted in idle leaves the fail flag clear
    p_fail_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && cmd_we && is_idle_opcode(bus_din)) |=> !stat.fail);

    // R6: an invalid block on program/erase sets fail
    p_fail_set_r6: assert property (@(posedge clk) disable iff (rst)
        (chk_pend && !st_blk_ok) |=> stat.fail);

    // R7: ready is low whenever the busy counter runs
    p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (rst)
        tmr_busy |-> !stat.ready);

    // R8: strobes during busy are flagged
    p_busy_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BUSY && (cmd_we || addr_we)) |=> err_evt);

    // R9: an erase fill is followed by the wear pulse
    p_wear_after_fill_r9: assert property (@(posedge clk) disable iff (rst)
        (st_op_vld && sto == STO_FILL) |=> st_wear_dec);
endmodule

// File: tb/nand_cmd_seq_test.sv
`timescale 1ns/1ps
module nand_cmd_seq_test;
    localparam int DLY_W = 16;
    localparam int BAD_BLK = 7;

    logic             clk = 1'b0;
    logic             rst;
    logic             cmd_we, addr_we;
    logic [7:0]       bus_din, cfg_addr_cyc;
    logic [DLY_W-1:0] cfg_rd_dly, cfg_pg_dly, cfg_er_dly;
    logic             wp_in;
    logic [7:0]       man_id, dev_id;
    logic [7:0]       status_q;
    logic             err_evt, err_addr;
    logic [2:0]       rsp_src;
    logic [31:0]      rsp_word;
    logic [15:0]      rsp_len;
    logic [7:0]       st_lun;
    logic [9:0]       st_blk;
    logic [5:0]       st_page;
    logic [15:0]      st_col;
    logic             st_blk_ok;
    logic             st_op_vld;
    logic [1:0]       st_op;
    logic             st_wear_dec;

    always #5 clk = ~clk;

    assign st_blk_ok = (st_blk != 10'(BAD_BLK));

    nand_cmd_seq uut (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .addr_we(addr_we), .bus_din(bus_din),
        .cfg_addr_cyc(cfg_addr_cyc), .cfg_rd_dly(cfg_rd_dly), .cfg_pg_dly(cfg_pg_dly),
        .cfg_er_dly(cfg_er_dly), .wp_in(wp_in), .man_id(man_id), .dev_id(dev_id),
        .status_q(status_q), .err_evt(err_evt), .err_addr(err_addr), .rsp_src(rsp_src),
        .rsp_word(rsp_word), .rsp_len(rsp_len), .st_lun(st_lun), .st_blk(st_blk),
        .st_page(st_page), .st_col(st_col), .st_blk_ok(st_blk_ok), .st_op_vld(st_op_vld),
        .st_op(st_op), .st_wear_dec(st_wear_dec)
    );

    typedef struct {
        int kind;   // 0 storage op, 1 wear pulse
        int op;
        int blk;
        int page;
        int col;
    } exp_t;

    exp_t sb[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst === 1'b0 && (st_op_vld === 1'b1 || st_wear_dec === 1'b1)) begin
            if (sb.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R9: unexpected storage pulse op=%0d wear=%0b expected none", st_op, st_wear_dec);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.kind == 0) begin
                    check("R9 op pulse", {31'b0, st_op_vld}, 32'd1);
                    check("R9 op code", 32'(st_op), 32'(e.op));
                    check("R4 op block", 32'(st_blk), 32'(e.blk));
                    check("R4 op page", 32'(st_page), 32'(e.page));
                    check("R4 op column", 32'(st_col), 32'(e.col));
                end else begin
                    check("R9 wear pulse", {31'b0, st_wear_dec}, 32'd1);
                    check("R9 wear block", 32'(st_blk), 32'(e.blk));
                end
            end
        end
    end

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        finish_run();
    end

    task automatic do_cmd(input logic [7:0] b);
        cmd_we = 1'b1; bus_din = b;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic do_addr(input logic [7:0] b);
        addr_we = 1'b1; bus_din = b;
        @(negedge clk);
        addr_we = 1'b0;
    endtask

    task automatic send_bytes(input logic [31:0] v, input int n);
        for (int i = 0; i < n; i++) do_addr(v[i*8 +: 8]);
    endtask

    task automatic push_op(input int op, input int row, input int col);
        exp_t e;
        e.kind = 0; e.op = op; e.blk = (row >> 6) & 1023; e.page = row & 63; e.col = col;
        sb.push_back(e);
    endtask

    task automatic push_wear(input int row);
        exp_t e;
        e.kind = 1; e.op = 0; e.blk = (row >> 6) & 1023; e.page = 0; e.col = 0;
        sb.push_back(e);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (status_q[6] == 1'b0 && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        rst = 1'b1; cmd_we = 0; addr_we = 0; bus_din = 0;
        cfg_addr_cyc = 8'h23; cfg_rd_dly = 0; cfg_pg_dly = 5; cfg_er_dly = 3;
        wp_in = 1'b0; man_id = 8'hA5; dev_id = 8'h3C;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R13 + reset state
        check("R13 reset status", 32'(status_q), 32'hC0);
        check("R1 reset source", 32'(rsp_src), 32'd0);

        // R1: only RESET after power-up
        do_cmd(8'h90);
        check("R1 foreign cmd flagged", {31'b0, err_evt}, 32'd1);
        do_addr(8'h00);
        check("R1 address flagged", {31'b0, err_evt}, 32'd1);
        check("R1 no identify", 32'(rsp_src), 32'd0);
        do_cmd(8'hFF);
        check("R1 reset accepted", {31'b0, err_evt}, 32'd0);

        // R10 identify
        do_cmd(8'h90); do_addr(8'h00);
        check("R10 id source", 32'(rsp_src), 32'd1);
        check("R10 id length", 32'(rsp_len), 32'd2);
        check("R10 id word", rsp_word, 32'h3CA5);
        do_cmd(8'hFF);
        check("R1 reset clears source", 32'(rsp_src), 32'd0);
        do_cmd(8'h90); do_addr(8'h20);
        check("R10 signature word", rsp_word, 32'h4946_4E4F);
        check("R10 signature length", 32'(rsp_len), 32'd4);
        do_cmd(8'h90); do_addr(8'h55);
        check("R10 bad address pulse", {31'b0, err_addr}, 32'd1);
        check("R10 bad address source", 32'(rsp_src), 32'd0);

        // R11 parameter page
        do_cmd(8'hEC); do_addr(8'h00);
        check("R11 param source", 32'(rsp_src), 32'd3);
        check("R11 param length", 32'(rsp_len), 32'd256);
        do_cmd(8'hEC); do_addr(8'h01);
        check("R11 bad address pulse", {31'b0, err_addr}, 32'd1);

        // R2 unknown opcode in idle
        do_cmd(8'h42);
        check("R2 unknown opcode", {31'b0, err_evt}, 32'd1);

        // R4 read, zero delay
        do_cmd(8'h00);
        send_bytes(32'h1234, 2);
        send_bytes(32'h030AC5, 3);
        check("R4 column", 32'(st_col), 32'h1234);
        check("R4 page", 32'(st_page), 32'h05);
        check("R4 block", 32'(st_blk), 32'h2B);
        check("R4 unit", 32'(st_lun), 32'h03);
        do_addr(8'h77);
        check("R12 ignored address no error", {31'b0, err_evt}, 32'd0);
        check("R12 ignored address column", 32'(st_col), 32'h1234);
        push_op(1, 32'h0AC5, 32'h1234);
        do_cmd(8'h30);
        check("R7 zero delay keeps ready", 32'(status_q[6]), 32'd1);
        @(negedge clk);
        check("R9 page source", 32'(rsp_src), 32'd4);

        // R7 program with delay 5
        do_cmd(8'h80);
        send_bytes(32'h0010, 2);
        send_bytes(32'h000142, 3);
        push_op(2, 32'h0142, 32'h0010);
        do_cmd(8'h10);
        wait_ready(n);
        check("R7 program busy cycles", 32'(n), 32'd5);

        // R6 program on invalid block
        do_cmd(8'h80);
        send_bytes(32'h0004, 2);
        send_bytes(32'h0001C3, 3);
        @(negedge clk);
        check("R6 fail set", 32'(status_q[0]), 32'd1);
        push_op(2, 32'h01C3, 32'h0004);
        do_cmd(8'h10);
        check("R6 confirm accepted", {31'b0, err_evt}, 32'd0);
        wait_ready(n);
        do_cmd(8'h90);
        check("R5 fail cleared", 32'(status_q[0]), 32'd0);
        do_addr(8'h00);

        // R3 + R9 erase with other cycle counts, delay 3
        cfg_addr_cyc = 8'h12;
        do_cmd(8'h60);
        send_bytes(32'h0241, 2);
        check("R3 two row bytes", 32'(st_blk), 32'd9);
        push_op(3, 32'h0241, 0);
        push_wear(32'h0241);
        do_cmd(8'hD0);
        wait_ready(n);
        check("R7 erase busy cycles", 32'(n), 32'd3);

        // R9 erase on invalid block, zero delay: wear only
        cfg_er_dly = 0;
        do_cmd(8'h60);
        send_bytes(32'h01C0, 2);
        push_wear(32'h01C0);
        do_cmd(8'hD0);
        check("R6 erase fail set", 32'(status_q[0]), 32'd1);
        repeat (3) @(negedge clk);

        // R12 wrong command during address collection
        do_cmd(8'h00);
        do_cmd(8'h90);
        check("R12 wrong command flagged", {31'b0, err_evt}, 32'd1);
        do_cmd(8'h90); do_addr(8'h00);
        check("R12 back in idle", 32'(rsp_src), 32'd1);

        // R12 wrong confirm
        do_cmd(8'h00);
        send_bytes(32'h0001, 1);
        send_bytes(32'h0041, 2);
        do_cmd(8'h10);
        check("R12 wrong confirm flagged", {31'b0, err_evt}, 32'd1);

        // R3 zero nibbles act as one byte
        cfg_addr_cyc = 8'h00;
        do_cmd(8'h00);
        do_addr(8'h05);
        do_addr(8'h46);
        check("R3 single column byte", 32'(st_col), 32'h05);
        check("R3 single row byte page", 32'(st_page), 32'h06);
        push_op(1, 32'h46, 32'h05);
        do_cmd(8'h30);

        // R8 strobe during busy
        cfg_pg_dly = 6;
        do_cmd(8'h80);
        do_addr(8'h00);
        do_addr(8'h80);
        push_op(2, 32'h80, 0);
        do_cmd(8'h10);
        do_cmd(8'h90);
        check("R8 busy strobe flagged", {31'b0, err_evt}, 32'd1);
        check("R8 still busy", 32'(status_q[6]), 32'd0);
        wait_ready(n);
        check("R8 busy length kept", 32'(n), 32'd5);
        check("R8 strobe ignored", 32'(rsp_src), 32'd4);

        repeat (3) @(negedge clk);
        check("R9 scoreboard drained", 32'(sb.size()), 32'd0);
        finish_run();
    end
endmodule